// File: doc/BRIEF.md
# Memory Barrier and Sleep Controller

This unit sits beside the execute stage of a small 32-bit core and carries out the barrier instruction. It keeps a count of the requests that each memory port has accepted but not yet completed. When the barrier issues, the unit holds the pipeline until the selected ports have no outstanding requests. If the instruction port was one of them, it then pulses a flush for the prefetch buffer and the branch target cache. Finally it releases the pipeline with a one-cycle PC-advance strobe.

The top bit of the five-bit immediate asks for sleep. With MMU support built in, that bit makes the instruction privileged, and user-mode code gets an exception request instead of a barrier. A legal sleep request first drains both ports completely. It then raises the sleep output and keeps the pipeline halted until any bit of the wakeup vector goes high.

A barrier that follows an immediate-prefix instruction, or that sits in a branch delay slot, is refused with an illegal-use pulse.

Top module: `barrier_sleep_unit`

## Requirements
- R1: A word counts as the barrier only when bits 31:26 hold 101110 and bits 20:0 hold 21'h020004. The immediate is taken from bits 25:21. Any other word presented with `issueValid` is ignored: no stall, no flush and no PC advance follow it.
- R2: When immediate bits 0 and 1 are both set and bit 4 is clear, `pcAdvance` pulses in the cycle after issue and `stallOut` never rises.
- R3: When immediate bit 1 is clear, the unit holds `stallOut` high until the data-side outstanding count is zero. If that count is already zero at issue, `pcAdvance` follows in the next cycle. Otherwise `pcAdvance` comes two cycles after the cycle in which the last completion is presented.
- R4: When immediate bit 0 is clear, the unit waits in the same way for the instruction side. It then raises `flushOut` for exactly one cycle, with stall held, and `pcAdvance` follows in the next cycle.
- R5: Each side's outstanding counter adds one per accept and subtracts one per completion. An accept and a completion in the same cycle leave it unchanged. It saturates at 2^CNT_W-1 and does not go below zero.
- R6: With MMU support on, immediate bit 4 set and `userMode` high, the issue cycle raises `excReq` with `excCause` = 7. No stall, flush, sleep or PC advance follows. `excCause` reads 0 whenever `excReq` is low.
- R7: When immediate bit 4 is set and no exception is taken, the unit waits until both counters are zero, whatever bits 0 and 1 say. It then asserts `sleepOut` with `stallOut` high and holds them while `wakeVec` is all zero. When bit 0 is also clear, the flush pulse comes before sleep.
- R8: Any nonzero `wakeVec` during sleep drops `sleepOut` in that same cycle, and `pcAdvance` pulses in the next cycle.
- R9: A recognised barrier issued with `prevWasPrefix` or `inDelaySlot` high raises `illegalUse` in the issue cycle and does nothing else. This takes priority over the privilege check.
- R10: `stallOut` is high only while draining, flushing or sleeping, and never together with `pcAdvance`. `pcAdvance` is a single-cycle pulse.
- R11: During reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction word is presented this cycle |
| instrWord | input | 32 | Instruction word being issued |
| prevWasPrefix | input | 1 | The previous instruction was an immediate prefix |
| inDelaySlot | input | 1 | The instruction sits in a branch delay slot |
| userMode | input | 1 | Core runs in user mode |
| iReqAccept | input | 1 | Instruction port accepted a request |
| iRespDone | input | 1 | Instruction port completed a request |
| dReqAccept | input | 1 | Data port accepted a request |
| dRespDone | input | 1 | Data port completed a request |
| wakeVec | input | WAKE_W | Wakeup sources |
| stallOut | output | 1 | Hold the pipeline |
| flushOut | output | 1 | Flush prefetch buffer and branch target cache |
| excReq | output | 1 | Privileged-instruction exception request |
| excCause | output | 5 | Exception cause code |
| pcAdvance | output | 1 | Barrier complete, advance PC by 4 |
| sleepOut | output | 1 | Core is asleep |
| illegalUse | output | 1 | Barrier placed after a prefix or in a delay slot |

## Verification
The hardest conditions to reach are a saturated counter and an accept that coincides with a completion. From the outside, both show up only as a change in when the barrier releases. The bench therefore builds up a known outstanding count with accept pulses, overruns the counter on purpose, and overlaps accepts with completions. It then times the release against the count it expects. The same timing model is swept over every wait selection, several preloaded counts on each side and sleep with each wakeup pattern, and the stall, flush, sleep and advance outputs are checked in every cycle.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam logic [5:0]  OPCODE_BITS = 6'b101110;
  localparam logic [20:0] TAIL_BITS   = 21'h020004;
  localparam logic [4:0]  PRIV_CAUSE  = 5'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FLUSH,
    ST_SLEEP,
    ST_DONE
  } seqState_t;

  // strobes from the sequencer to the tracking datapath
  typedef struct packed {
    logic latchCmd;
    logic releaseCmd;
  } ctlStrobe_t;

  typedef struct packed {
    logic waitI;
    logic waitD;
    logic sleep;
  } barrierCmd_t;
endpackage

// File: rtl/outstanding_ctr.sv
module outstanding_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqAccept,
  input  logic respDone,
  output logic isZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({reqAccept, respDone})
        2'b10:   if (count != CNT_MAX) count <= count + 1'b1;
        2'b01:   if (count != '0)      count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign isZero = (count == '0);
endmodule

// File: rtl/barrier_track.sv
module barrier_track
  import barrier_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instrWord,
  input  logic        iReqAccept,
  input  logic        iRespDone,
  input  logic        dReqAccept,
  input  logic        dRespDone,
  input  ctlStrobe_t  strobe,
  output logic        decHit,
  output logic        freshWaitI,
  output logic        freshSleep,
  output logic        freshDrained,
  output logic        heldWaitI,
  output logic        heldSleep,
  output logic        heldDrained
);
  localparam int SIDES = 2;

  logic [SIDES-1:0] sideAcc;
  logic [SIDES-1:0] sideDone;
  logic [SIDES-1:0] sideZero;
  logic [4:0]       immField;
  barrierCmd_t      freshCmd;
  barrierCmd_t      heldCmd;

  assign sideAcc  = {dReqAccept, iReqAccept};
  assign sideDone = {dRespDone, iRespDone};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    outstanding_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rstN     (rstN),
      .reqAccept(sideAcc[s]),
      .respDone (sideDone[s]),
      .isZero   (sideZero[s])
    );
  end

  // decode of the fixed fields and the immediate
  assign immField = instrWord[25:21];
  assign decHit   = (instrWord[31:26] == OPCODE_BITS) && (instrWord[20:0] == TAIL_BITS);

  always_comb begin
    freshCmd.waitI = ~immField[0];
    freshCmd.waitD = ~immField[1];
    freshCmd.sleep = immField[4];
  end

  function automatic logic drainedFor(barrierCmd_t c, logic [SIDES-1:0] z);
    logic needI;
    logic needD;
    needI = c.waitI | c.sleep;
    needD = c.waitD | c.sleep;
    return (~needI | z[0]) & (~needD | z[1]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCmd <= '0;
    end else if (strobe.latchCmd) begin
      heldCmd <= freshCmd;
    end else if (strobe.releaseCmd) begin
      heldCmd <= '0;
    end
  end

  assign freshWaitI   = freshCmd.waitI;
  assign freshSleep   = freshCmd.sleep;
  assign freshDrained = drainedFor(freshCmd, sideZero);
  assign heldWaitI    = heldCmd.waitI;
  assign heldSleep    = heldCmd.sleep;
  assign heldDrained  = drainedFor(heldCmd, sideZero);
endmodule

// File: rtl/barrier_seq.sv
module barrier_seq
  import barrier_pkg::*;
#(
  parameter bit MMU_ON = 1'b1,
  parameter int WAKE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              prevWasPrefix,
  input  logic              inDelaySlot,
  input  logic              userMode,
  input  logic [WAKE_W-1:0] wakeVec,
  input  logic              decHit,
  input  logic              freshWaitI,
  input  logic              freshSleep,
  input  logic              freshDrained,
  input  logic              heldWaitI,
  input  logic              heldSleep,
  input  logic              heldDrained,
  output ctlStrobe_t        strobe,
  output logic              stallOut,
  output logic              flushOut,
  output logic              excReq,
  output logic [4:0]        excCause,
  output logic              pcAdvance,
  output logic              sleepOut,
  output logic              illegalUse
);
  seqState_t state;
  seqState_t stateNext;
  logic      take;
  logic      badPlace;
  logic      privFault;
  logic      goExec;
  logic      wakeSeen;

  assign take      = (state == ST_IDLE) && issueValid && decHit;
  assign badPlace  = take && (prevWasPrefix || inDelaySlot);
  assign privFault = take && !badPlace && MMU_ON && freshSleep && userMode;
  assign goExec    = take && !badPlace && !privFault;
  assign wakeSeen  = |wakeVec;

  function automatic seqState_t afterDrain(logic wantFlush, logic wantSleep);
    if (wantFlush)      return ST_FLUSH;
    else if (wantSleep) return ST_SLEEP;
    else                return ST_DONE;
  endfunction

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:
        if (goExec) stateNext = freshDrained ? afterDrain(freshWaitI, freshSleep) : ST_DRAIN;
      ST_DRAIN:
        if (heldDrained) stateNext = afterDrain(heldWaitI, heldSleep);
      ST_FLUSH:
        stateNext = heldSleep ? ST_SLEEP : ST_DONE;
      ST_SLEEP:
        if (wakeSeen) stateNext = ST_DONE;
      ST_DONE:
        stateNext = ST_IDLE;
      default:
        stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchCmd   = goExec;
    strobe.releaseCmd = (state == ST_DONE);
  end

  assign stallOut   = (state == ST_DRAIN) || (state == ST_FLUSH) || (state == ST_SLEEP);
  assign flushOut   = (state == ST_FLUSH);
  assign sleepOut   = (state == ST_SLEEP) && !wakeSeen;
  assign pcAdvance  = (state == ST_DONE);
  assign excReq     = privFault;
  assign excCause   = privFault ? PRIV_CAUSE : 5'd0;
  assign illegalUse = badPlace;
endmodule

// File: rtl/barrier_sleep_unit.sv
module barrier_sleep_unit
  import barrier_pkg::*;
#(
  parameter bit MMU_ON = 1'b1,
  parameter int CNT_W  = 4,
  parameter int WAKE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [31:0]       instrWord,
  input  logic              prevWasPrefix,
  input  logic              inDelaySlot,
  input  logic              userMode,
  input  logic              iReqAccept,
  input  logic              iRespDone,
  input  logic              dReqAccept,
  input  logic              dRespDone,
  input  logic [WAKE_W-1:0] wakeVec,
  output logic              stallOut,
  output logic              flushOut,
  output logic              excReq,
  output logic [4:0]        excCause,
  output logic              pcAdvance,
  output logic              sleepOut,
  output logic              illegalUse
);
  ctlStrobe_t strobe;
  logic decHit;
  logic freshWaitI;
  logic freshSleep;
  logic freshDrained;
  logic heldWaitI;
  logic heldSleep;
  logic heldDrained;

  barrier_track #(.CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rstN        (rstN),
    .instrWord   (instrWord),
    .iReqAccept  (iReqAccept),
    .iRespDone   (iRespDone),
    .dReqAccept  (dReqAccept),
    .dRespDone   (dRespDone),
    .strobe      (strobe),
    .decHit      (decHit),
    .freshWaitI  (freshWaitI),
    .freshSleep  (freshSleep),
    .freshDrained(freshDrained),
    .heldWaitI   (heldWaitI),
    .heldSleep   (heldSleep),
    .heldDrained (heldDrained)
  );

  barrier_seq #(.MMU_ON(MMU_ON), .WAKE_W(WAKE_W)) u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .issueValid   (issueValid),
    .prevWasPrefix(prevWasPrefix),
    .inDelaySlot  (inDelaySlot),
    .userMode     (userMode),
    .wakeVec      (wakeVec),
    .decHit       (decHit),
    .freshWaitI   (freshWaitI),
    .freshSleep   (freshSleep),
    .freshDrained (freshDrained),
    .heldWaitI    (heldWaitI),
    .heldSleep    (heldSleep),
    .heldDrained  (heldDrained),
    .strobe       (strobe),
    .stallOut     (stallOut),
    .flushOut     (flushOut),
    .excReq       (excReq),
    .excCause     (excCause),
    .pcAdvance    (pcAdvance),
    .sleepOut     (sleepOut),
    .illegalUse   (illegalUse)
  );
endmodule

// File: rtl/barrier_chk.sv
module barrier_chk #(
  parameter int WAKE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [31:0]       instrWord,
  input logic              prevWasPrefix,
  input logic              inDelaySlot,
  input logic              userMode,
  input logic              iReqAccept,
  input logic              iRespDone,
  input logic              dReqAccept,
  input logic              dRespDone,
  input logic [WAKE_W-1:0] wakeVec,
  input logic              stallOut,
  input logic              flushOut,
  input logic              excReq,
  input logic [4:0]        excCause,
  input logic              pcAdvance,
  input logic              sleepOut,
  input logic              illegalUse
);
  a_r10_stall_blocks_advance: assert property (@(posedge clk) disable iff (!rstN)
    stallOut |-> !pcAdvance);

  a_r10_advance_single: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |=> !pcAdvance);

  a_r4_flush_single: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut);

  a_r4_flush_stalled: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> stallOut);

  a_r7_sleep_stalled: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |-> stallOut);

  a_r8_wake_releases: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepOut) |=> pcAdvance);

  a_r6_cause_code: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excCause == 5'd7) && !stallOut);

  a_r6_no_advance_after_exc: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> !pcAdvance && !stallOut);

  a_r9_illegal_not_exc: assert property (@(posedge clk) disable iff (!rstN)
    illegalUse |-> !excReq);
endmodule

bind barrier_sleep_unit barrier_chk #(.WAKE_W(WAKE_W)) u_chk (.*);

// File: tb/sim_barrier_sleep_unit.sv
`timescale 1ns/1ps
module sim_barrier_sleep_unit;
  localparam int WAKE_W = 2;
  localparam int CNT_W  = 2;

  logic clk = 1'b0;
  logic rstN;
  logic issueValid, prevWasPrefix, inDelaySlot, userMode;
  logic [31:0] instrWord;
  logic iReqAccept, iRespDone, dReqAccept, dRespDone;
  logic [WAKE_W-1:0] wakeVec;
  logic stallOut, flushOut, excReq, pcAdvance, sleepOut, illegalUse;
  logic [4:0] excCause;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  barrier_sleep_unit #(.MMU_ON(1'b1), .CNT_W(CNT_W), .WAKE_W(WAKE_W)) u0 (.*);

  function automatic logic [31:0] mk(input logic [4:0] imm);
    return {6'b101110, imm, 21'h020004};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn;
    issueValid = 0; instrWord = '0; prevWasPrefix = 0; inDelaySlot = 0; userMode = 0;
    iReqAccept = 0; iRespDone = 0; dReqAccept = 0; dRespDone = 0; wakeVec = '0;
  endtask

  task automatic preload(input int nI, input int nD);
    for (int k = 0; k < nI || k < nD; k++) begin
      iReqAccept = (k < nI);
      dReqAccept = (k < nD);
      tick;
    end
    iReqAccept = 0; dReqAccept = 0;
  endtask

  // cnt* are the outstanding counts the requirements predict
  task automatic runCase(input logic [4:0] imm, input int cntI, input int cntD,
                         input logic [WAKE_W-1:0] wp);
    int remI, remD, need, base, sEdge, fin;
    bit wI, wD, sl;
    string advTag;
    remI = cntI; remD = cntD;
    wI = !imm[0]; wD = !imm[1]; sl = imm[4];
    need = 0;
    if (wI || sl) need = cntI;
    if ((wD || sl) && cntD > need) need = cntD;
    base  = (need == 0) ? 1 : need + 2;
    sEdge = base + (wI ? 1 : 0);
    fin   = sl ? sEdge + 4 : sEdge;
    advTag = sl ? "R8 advance after wake" : wI ? "R4 advance after flush" :
             wD ? "R3 advance after data drain" : "R2 single-cycle advance";
    issueValid = 1; instrWord = mk(imm);
    @(negedge clk);
    check("R10 no stall at issue", stallOut, 0);
    tick;
    issueValid = 0; instrWord = '0;
    for (int c = 1; c <= fin; c++) begin
      iRespDone = (remI > 0); if (remI > 0) remI--;
      dRespDone = (remD > 0); if (remD > 0) remD--;
      wakeVec = (sl && c == sEdge + 3) ? wp : '0;
      @(negedge clk);
      check("R10 stall window", stallOut, c < fin);
      check(advTag, pcAdvance, c == fin);
      check("R4 flush pulse", flushOut, wI && c == base);
      check("R7 sleep held", sleepOut, sl && c >= sEdge && c < sEdge + 3);
      tick;
    end
    iRespDone = 0; dRespDone = 0; wakeVec = '0;
    while (remI > 0 || remD > 0) begin
      iRespDone = (remI > 0); if (remI > 0) remI--;
      dRespDone = (remD > 0); if (remD > 0) remD--;
      tick;
    end
    iRespDone = 0; dRespDone = 0;
    @(negedge clk);
    check("R10 idle after case", stallOut, 0);
    tick;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] badWords [4];
    clearIn();
    rstN = 0;
    repeat (3) tick;
    @(negedge clk);
    // R11 reset state
    check("R11 stall", stallOut, 0);
    check("R11 flush", flushOut, 0);
    check("R11 sleep", sleepOut, 0);
    check("R11 advance", pcAdvance, 0);
    check("R11 exc", {excReq, excCause}, 0);
    check("R11 illegal", illegalUse, 0);
    tick;
    rstN = 1;
    tick;

    // R1 non-matching words are ignored
    badWords[0] = mk(5'd0) ^ 32'h8000_0000;
    badWords[1] = mk(5'd0) ^ 32'h0400_0000;
    badWords[2] = mk(5'd0) ^ 32'h0000_0004;
    badWords[3] = mk(5'd0) ^ 32'h0010_0000;
    for (int w = 0; w < 4; w++) begin
      issueValid = 1; instrWord = badWords[w];
      tick;
      issueValid = 0; instrWord = '0;
      @(negedge clk);
      check("R1 ignored stall", stallOut, 0);
      check("R1 ignored flush", flushOut, 0);
      check("R1 ignored advance", pcAdvance, 0);
      tick;
    end

    // sweep of wait selections, counts and sleep
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 4; b++)
        for (int ni = 0; ni < 3; ni++)
          for (int nd = 0; nd < 3; nd++) begin
            logic [4:0] imm;
            imm = {s[0], 2'b00, b[1:0]};
            preload(ni, nd);
            runCase(imm, ni, nd, 2'((ni + nd) % 3 + 1));
          end

    // R5 saturation: 5 accepts on a 2-bit counter leave 3 outstanding
    preload(0, 5);
    runCase(5'b00001, 0, 3, 2'b01);
    // R5 accept and completion together leave the count unchanged
    preload(0, 2);
    for (int k = 0; k < 3; k++) begin
      dReqAccept = 1; dRespDone = 1; tick;
    end
    dReqAccept = 0; dRespDone = 0;
    runCase(5'b00001, 0, 2, 2'b10);

    // R6 privileged sleep in user mode
    userMode = 1; issueValid = 1; instrWord = mk(5'b10011);
    @(negedge clk);
    check("R6 exception raised", excReq, 1);
    check("R6 cause code", excCause, 7);
    tick;
    issueValid = 0; instrWord = '0;
    @(negedge clk);
    check("R6 no stall", stallOut, 0);
    check("R6 no advance", pcAdvance, 0);
    check("R6 no sleep", sleepOut, 0);
    check("R6 cause idle", excCause, 0);
    tick;
    // R6 non-privileged barrier still runs in user mode
    issueValid = 1; instrWord = mk(5'b00011);
    @(negedge clk);
    check("R6 no exception", excReq, 0);
    tick;
    issueValid = 0; instrWord = '0;
    @(negedge clk);
    check("R2 user-mode advance", pcAdvance, 1);
    tick;
    userMode = 0;

    // R9 illegal placement, including over a privileged word
    for (int m = 0; m < 2; m++) begin
      prevWasPrefix = (m == 0); inDelaySlot = (m == 1); userMode = 1;
      issueValid = 1; instrWord = mk(5'b10000);
      @(negedge clk);
      check("R9 illegal flagged", illegalUse, 1);
      check("R9 no exception", excReq, 0);
      tick;
      clearIn();
      @(negedge clk);
      check("R9 no stall", stallOut, 0);
      check("R9 no flush", flushOut, 0);
      check("R9 no advance", pcAdvance, 0);
      tick;
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule